// File: doc/BRIEF.md
# Programmable Sample Delay Line

This block takes a stream of 8-bit samples, each marked by a one-cycle valid strobe, and plays the same stream back a programmable number of sample periods later. Samples go into a circular buffer in on-chip dual-port memory. After reset the block is idle. The first strobe starts a fill phase. Once as many samples as the delay setting have been written, a one-shot start event launches playback. From then on, every strobe writes one new sample and reads one old sample, so the distance between the write and read pointers stays fixed at the delay.

The delay is counted in sample strobes, not in clock cycles, so the sample clock can run slower than the core clock and strobes may have gaps. The delay setting is clamped into a window set by parameters, and it is captured only while the block is idle. For a 20 MSa/s stream, the full-rate configuration is `ADDR_W=14` (16384 entries), `DELAY_MIN=7000` and `DELAY_MAX=9000`. That is 350 µs to 450 µs. The default parameters are a scaled-down version with the same shape. The output word drives a resistor-ladder DAC directly and holds its value between strobes.

Top module: `sample_delay_line`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `out_valid` and `playing` are 0 and `out_data` is 0.
- R2: The captured delay D is `delay_cfg` clamped into the parameter window: below `DELAY_MIN` becomes `DELAY_MIN`, above `DELAY_MAX` becomes `DELAY_MAX`, and in-range values are kept exactly.
- R3: `delay_cfg` is sampled on every cycle while the block is idle, up to and including the cycle of the first strobe after reset. Later changes have no effect on D until the next reset.
- R4: For strobes 0 to D-1 after reset (counting from 0), `out_valid` and `playing` stay 0.
- R5: Strobe number k, with k >= D, produces exactly one `out_valid` pulse on the clock cycle after the strobe, carrying the sample of strobe k-D. `playing` rises together with the first such pulse.
- R6: `out_data` changes only together with an `out_valid` pulse. It holds its last value otherwise, and holds 0 until the first read returns.
- R7: The write and read addresses wrap modulo 2^ADDR_W, and the output stays correct when more samples stream than the buffer holds.
- R8: A synchronous reset during playback drops `playing` and clears both pointers and the fill counter. The next strobe starts a fresh fill with a newly captured delay.
- R9: Cycles without a strobe advance nothing. Neither pointer, the fill count nor the output changes, and `in_data` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | One-cycle strobe marking a new input sample |
| in_data | input | DATA_W | Input sample, taken when `in_valid` is 1 |
| delay_cfg | input | CFG_W | Requested delay in sample periods |
| out_data | output | DATA_W | Delayed sample word for the DAC, held between reads |
| out_valid | output | 1 | One-cycle strobe marking a new output sample |
| playing | output | 1 | High once playback has started |

## Verification
The bench sweeps every value of a 5-bit delay setting against a small 32-entry buffer with a window of 3 to 12. This covers settings below, inside and above the window. A design with wrong clamping or an off-by-one fill counter would produce its first output sample at the wrong strobe index, or would pair outputs with the wrong inputs. The bench changes the setting just after the first strobe, so a design that keeps tracking the input would shift the delay in the middle of the stream. Strobe gaps carrying junk data, and runs long enough to wrap the buffer several times, expose pointers that advance on idle cycles or that wrap wrongly. A reset taken in the middle of playback shows whether the playing flag and both pointers really restart.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
   typedef enum logic [1:0] {
      SDL_IDLE = 2'd0,
      SDL_FILL = 2'd1,
      SDL_PLAY = 2'd2
   } sdl_state_e;
endpackage

// File: rtl/sdl_ctrl.sv
module sdl_ctrl
   import sdl_pkg::*;
#(
   parameter int CFG_W     = 16,
   parameter int DELAY_MIN = 1400,
   parameter int DELAY_MAX = 1800,
   localparam int DLY_W    = $clog2(DELAY_MAX + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [CFG_W-1:0] delay_cfg,
   output sdl_state_e       state_q,
   output logic [DLY_W-1:0] delay_q,
   output logic             fire,
   output logic             rd_en,
   output logic             playing
);
   localparam int CMP_W = ((CFG_W > DLY_W) ? CFG_W : DLY_W) + 1;

   logic [CMP_W-1:0] cfg_wide;
   logic [DLY_W-1:0] clamped;
   logic [DLY_W-1:0] fill_cnt_q;

   // range check of the requested delay
   always_comb begin
      cfg_wide = CMP_W'(delay_cfg);
      if (cfg_wide < CMP_W'(DELAY_MIN))
         clamped = DLY_W'(DELAY_MIN);
      else if (cfg_wide > CMP_W'(DELAY_MAX))
         clamped = DLY_W'(DELAY_MAX);
      else
         clamped = DLY_W'(cfg_wide);
   end

   assign fire    = (state_q == SDL_FILL) && in_valid && (fill_cnt_q == delay_q);
   assign rd_en   = in_valid && (fire || (state_q == SDL_PLAY));
   assign playing = (state_q == SDL_PLAY);

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q    <= SDL_IDLE;
         fill_cnt_q <= '0;
         delay_q    <= clamped;
      end else begin
         unique case (state_q)
            SDL_IDLE: begin
               delay_q <= clamped;
               if (in_valid) begin
                  state_q    <= SDL_FILL;
                  fill_cnt_q <= DLY_W'(1);
               end
            end
            SDL_FILL: begin
               if (in_valid) begin
                  if (fill_cnt_q == delay_q)
                     state_q <= SDL_PLAY;
                  else
                     fill_cnt_q <= fill_cnt_q + DLY_W'(1);
               end
            end
            default: begin
               state_q <= SDL_PLAY;
            end
         endcase
      end
   end
endmodule

// File: rtl/sdl_ptrs.sv
module sdl_ptrs #(
   parameter int ADDR_W = 11,
   parameter int DLY_W  = 11
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic              fire,
   input  logic              rd_en,
   input  logic [DLY_W-1:0]  delay_q,
   output logic [ADDR_W-1:0] wp_q,
   output logic [ADDR_W-1:0] rp_q,
   output logic [ADDR_W-1:0] rd_addr
);
   // on the start event the read side jumps to wp - D (mod depth)
   assign rd_addr = fire ? (wp_q - ADDR_W'(delay_q)) : rp_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         wp_q <= '0;
         rp_q <= '0;
      end else begin
         if (in_valid)
            wp_q <= wp_q + ADDR_W'(1);
         if (rd_en)
            rp_q <= rd_addr + ADDR_W'(1);
      end
   end
endmodule

// File: rtl/sdl_dpram.sv
module sdl_dpram #(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              re,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we)
         mem[waddr] <= wdata;
   end

   // registered read port, one cycle of latency
   always_ff @(posedge clk) begin
      if (rst) begin
         rdata  <= '0;
         rvalid <= 1'b0;
      end else begin
         rvalid <= re;
         if (re)
            rdata <= mem[raddr];
      end
   end
endmodule

// File: rtl/sample_delay_line.sv
module sample_delay_line
   import sdl_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 11,
   parameter int CFG_W     = 16,
   parameter int DELAY_MIN = 1400,
   parameter int DELAY_MAX = 1800
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic [CFG_W-1:0]  delay_cfg,
   output logic [DATA_W-1:0] out_data,
   output logic              out_valid,
   output logic              playing
);
   localparam int DLY_W = $clog2(DELAY_MAX + 1);
   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (DELAY_MIN < 1) begin : g_bad_min
         $error("DELAY_MIN must be at least 1");
      end
      if (DELAY_MAX < DELAY_MIN) begin : g_bad_order
         $error("DELAY_MAX must not be below DELAY_MIN");
      end
      if (DELAY_MAX >= DEPTH) begin : g_bad_depth
         $error("DELAY_MAX must be below the buffer depth");
      end
      if (DATA_W < 1 || CFG_W < 1) begin : g_bad_width
         $error("DATA_W and CFG_W must be positive");
      end
   endgenerate

   sdl_state_e        state_q;
   logic [DLY_W-1:0]  delay_q;
   logic              fire;
   logic              rd_en;
   logic              idle;
   logic [ADDR_W-1:0] wp_q;
   logic [ADDR_W-1:0] rp_q;
   logic [ADDR_W-1:0] rd_addr;

   assign idle = (state_q == SDL_IDLE);

   sdl_ctrl #(
      .CFG_W     (CFG_W),
      .DELAY_MIN (DELAY_MIN),
      .DELAY_MAX (DELAY_MAX)
   ) u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .delay_cfg (delay_cfg),
      .state_q   (state_q),
      .delay_q   (delay_q),
      .fire      (fire),
      .rd_en     (rd_en),
      .playing   (playing)
   );

   sdl_ptrs #(
      .ADDR_W (ADDR_W),
      .DLY_W  (DLY_W)
   ) u_ptrs (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid),
      .fire     (fire),
      .rd_en    (rd_en),
      .delay_q  (delay_q),
      .wp_q     (wp_q),
      .rp_q     (rp_q),
      .rd_addr  (rd_addr)
   );

   sdl_dpram #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_ram (
      .clk    (clk),
      .rst    (rst),
      .we     (in_valid),
      .waddr  (wp_q),
      .wdata  (in_data),
      .re     (rd_en),
      .raddr  (rd_addr),
      .rdata  (out_data),
      .rvalid (out_valid)
   );
endmodule

// File: rtl/sdl_chk.sv
module sdl_chk #(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 11,
   parameter int DELAY_MIN = 1400,
   parameter int DELAY_MAX = 1800,
   localparam int DLY_W    = $clog2(DELAY_MAX + 1)
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic [DATA_W-1:0] out_data,
   input logic              out_valid,
   input logic              playing,
   input logic              idle,
   input logic [DLY_W-1:0]  delay_q,
   input logic [ADDR_W-1:0] wp_q,
   input logic [ADDR_W-1:0] rp_q
);
   AST_RESET_QUIET: assert property (@(posedge clk)
      $past(rst) |-> (!out_valid && !playing && out_data == '0)); // R1

   AST_DELAY_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
      (delay_q >= DLY_W'(DELAY_MIN)) && (delay_q <= DLY_W'(DELAY_MAX))); // R2

   AST_DELAY_FROZEN: assert property (@(posedge clk) disable iff (rst)
      (!idle && !$past(idle)) |-> $stable(delay_q)); // R3

   AST_VALID_NEEDS_PLAY: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> playing); // R4

   AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(in_valid)); // R5

   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!out_valid && !$past(rst)) |-> $stable(out_data)); // R6

   AST_POINTER_GAP: assert property (@(posedge clk) disable iff (rst)
      playing |-> (ADDR_W'(wp_q - rp_q) == ADDR_W'(delay_q))); // R7

   AST_IDLE_CYCLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(wp_q) && $stable(rp_q))); // R9
endmodule

bind sample_delay_line sdl_chk #(
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W),
   .DELAY_MIN (DELAY_MIN),
   .DELAY_MAX (DELAY_MAX)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .out_data  (out_data),
   .out_valid (out_valid),
   .playing   (playing),
   .idle      (idle),
   .delay_q   (delay_q),
   .wp_q      (wp_q),
   .rp_q      (rp_q)
);

// File: tb/sample_delay_line_tb.sv
module sample_delay_line_tb;
   localparam int ADDR_W = 5;
   localparam int DATA_W = 8;
   localparam int CFG_W  = 5;
   localparam int DMIN   = 3;
   localparam int DMAX   = 12;
   localparam int DEPTH  = 1 << ADDR_W;

   logic              clk = 1'b0;
   logic              rst;
   logic              in_valid;
   logic [DATA_W-1:0] in_data;
   logic [CFG_W-1:0]  delay_cfg;
   logic [DATA_W-1:0] out_data;
   logic              out_valid;
   logic              playing;

   always #4 clk = ~clk;

   sample_delay_line #(
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .CFG_W     (CFG_W),
      .DELAY_MIN (DMIN),
      .DELAY_MAX (DMAX)
   ) u_dut (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .delay_cfg (delay_cfg),
      .out_data  (out_data),
      .out_valid (out_valid),
      .playing   (playing)
   );

   int total = 0;
   int bad   = 0;
   logic [DATA_W-1:0] hist [0:1023];
   int n;
   int d_exp;
   int first_seen;
   logic [DATA_W-1:0] exp_data;

   function automatic int clamp_of(int v);
      if (v < DMIN) return DMIN;
      if (v > DMAX) return DMAX;
      return v;
   endfunction

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic do_reset(input logic [CFG_W-1:0] cfg_pre);
      @(negedge clk);
      rst       = 1'b1;
      in_valid  = 1'b0;
      in_data   = 8'hA5;
      delay_cfg = cfg_pre;
      repeat (2) @(negedge clk);
      rst        = 1'b0;
      n          = 0;
      first_seen = -1;
      exp_data   = '0;
      chk("R1", "out_valid in reset",  32'(out_valid), 32'd0);
      chk("R8", "playing after reset", 32'(playing),   32'd0);
      chk("R1", "out_data in reset",   32'(out_data),  32'd0);
   endtask

   task automatic step(input logic v, input logic [DATA_W-1:0] d);
      logic exp_valid;
      string vtag;
      string dtag;
      in_valid = v;
      in_data  = d;
      @(negedge clk);
      exp_valid = 1'b0;
      vtag = "R4";
      dtag = "R6";
      if (v) begin
         hist[n] = d;
         if (n >= d_exp) begin
            exp_valid = 1'b1;
            exp_data  = hist[n - d_exp];
            vtag = "R5";
            dtag = (n >= DEPTH) ? "R7" : "R5";
         end
         n++;
      end else begin
         vtag = "R9";
         dtag = "R9";
      end
      if (out_valid === 1'b1 && first_seen < 0)
         first_seen = n - 1;
      chk(vtag, "out_valid", 32'(out_valid), 32'(exp_valid));
      chk((n > d_exp) ? "R5" : "R4", "playing", 32'(playing), 32'(n > d_exp));
      chk(dtag, "out_data", 32'(out_data), 32'(exp_data));
   endtask

   initial begin
      rst       = 1'b1;
      in_valid  = 1'b0;
      in_data   = '0;
      delay_cfg = '0;
      for (int c = 0; c < (1 << CFG_W); c++) begin
         do_reset(CFG_W'((c * 7 + 5) % (1 << CFG_W)));
         // idle cycles: the setting is still tracked, junk data is ignored
         delay_cfg = CFG_W'(c);
         d_exp = clamp_of(c);
         step(1'b0, 8'h3C);
         step(1'b0, 8'hC3);
         for (int i = 0; i < 100; i++) begin
            step((i % 6) != 4, DATA_W'(i * 37 + c * 11 + 1));
            if (i == 0)
               delay_cfg = CFG_W'((c + 9) % (1 << CFG_W)); // R3: ignored from here
         end
         chk("R2/R3", "first output strobe index", 32'(first_seen), 32'(d_exp));
         // loop continues into a reset taken during playback (R8)
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog R5 actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule